// File: doc/BRIEF.md
# Multicarrier Level-Shifted PWM Modulator

This block turns a stream of signed reference samples into the switching pattern for one leg of a multilevel inverter with an odd number of output levels (3 or 5). It keeps N-1 triangular carriers stacked on top of each other, each covering one band of the reference range. It compares the latest reference against all of them at once. The number of carriers that the reference lies strictly above gives the output level.

All carriers are derived from one shared up/down counter. Each carrier either follows the counter or its complement (period minus count), so three phase arrangements are available: every carrier aligned, carriers above zero opposed to those below zero, or neighbours alternating. The period and the arrangement are sampled only at the valley of the counter, so a change never cuts a carrier half-way through.

Reference samples arrive on a valid/ready interface. The block never applies back-pressure: ready is low while reset is asserted and high from the first clock after reset. A sample is accepted on every clock edge at which valid and ready are both high. It remains in use until the next accepted sample. A producer may therefore hold valid high and update the sample once per switching period, or once per clock.

Top module: `mpwm_modulator`

## Requirements
- R1: While reset is asserted, level is 0, every bit of gate_hi and gate_lo is 0 and ref_ready is 0.
- R2: The shared counter starts at 0 and rises by one per clock to the period P, then falls by one per clock back to 0, so one carrier cycle lasts 2P clocks. Carrier k (k = 0 is the lowest, M = N-1 carriers) equals (k - M/2)*P plus either the count or P minus the count. When P is 0, every carrier sits at (k - M/2)*0 = 0.
- R3: At each clock edge after reset, level becomes C - M/2, where C is the number of carriers that the held reference is strictly greater than, evaluated on the state before that edge (one register stage).
- R4: With mode 0 (and with mode 3, treated identically), every carrier follows the count.
- R5: With mode 1, carriers with k >= M/2 (above zero) follow the count and carriers with k < M/2 use P minus the count.
- R6: With mode 2, carriers with even k follow the count and carriers with odd k use P minus the count.
- R7: The period and mode inputs are taken only at a clock edge where the counter is 0. That same edge already steps the counter with the new period. At every other edge, changes on these inputs have no effect.
- R8: gate_hi bit j (j = 0 is the outermost switch) is 1 exactly when C >= M - j, and gate_lo is its bitwise complement. For 3 levels this gives: C=2, both upper switches on (positive rail); C=1, inner upper and outer lower on (neutral point); C=0, both lower switches on (negative rail).
- R9: ref_data is captured when ref_valid and ref_ready are both high at a clock edge. Otherwise the held reference is unchanged.
- R10: A reference above M/2*P drives level to +M/2. A reference at or below -M/2*P drives level to -M/2, independent of carrier position and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period | input | CW | Carrier peak count P, sampled at the counter valley |
| mode | input | 2 | Carrier phase arrangement, sampled at the counter valley |
| ref_data | input | REF_W | Signed reference sample |
| ref_valid | input | 1 | Reference sample present |
| ref_ready | output | 1 | Block accepts samples (high after reset) |
| level | output | $clog2(LEVELS)+1 | Signed output level index, -M/2 to +M/2 |
| gate_hi | output | LEVELS-1 | Upper switch gates, bit 0 outermost |
| gate_lo | output | LEVELS-1 | Lower switch gates, complement of gate_hi after reset |

## Verification
The case most likely to break the block is a clock edge at which the counter valley, and with it the loading of a new mode and period, coincides with the acceptance of a new reference sample. The comparison in that cycle must still use the old arrangement and the old sample, and the next cycle must use both new values. The bench toggles the mode every five clocks while a sinusoidal reference streams in on every clock, and it also changes the period. The two events therefore repeatedly fall on the same edge for both a 5-level and a 3-level instance. A behavioural model predicts level and gates on every clock, and any disagreement at those edges shows up directly.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;

  typedef enum logic [1:0] {
    CARR_ALIGNED   = 2'd0,
    CARR_OPPOSED   = 2'd1,
    CARR_ALTERNATE = 2'd2,
    CARR_ALIGNED_B = 2'd3
  } carrier_mode_e;

  // True when carrier k of m carriers runs on the complemented count.
  function automatic logic carrier_inverted(carrier_mode_e md, int k, int m);
    case (md)
      CARR_OPPOSED:   return (k < m / 2);
      CARR_ALTERNATE: return (k % 2) == 1;
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mpwm_tri_counter.sv
`timescale 1ns/1ps
module mpwm_tri_counter
  import mpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_in,
  input  logic [1:0]    mode_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] period_q,
  output carrier_mode_e mode_q
);

  logic          rising;
  logic          valley;
  logic [CW-1:0] p_eff;
  logic [CW:0]   cnt_inc;

  assign valley  = (cnt == '0);
  assign p_eff   = valley ? period_in : period_q;
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  // Configuration is taken only at the valley
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      mode_q   <= CARR_ALIGNED;
    end else if (valley) begin
      period_q <= period_in;
      mode_q   <= carrier_mode_e'(mode_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt_inc >= {1'b0, p_eff}) begin
        cnt    <= p_eff;
        rising <= 1'b0;
      end else begin
        cnt <= cnt_inc[CW-1:0];
      end
    end else begin
      if (cnt <= 1) begin
        cnt    <= '0;
        rising <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mpwm_carrier_compare.sv
`timescale 1ns/1ps
module mpwm_carrier_compare
  import mpwm_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int CW     = 8,
  parameter int REF_W  = 10,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = NCAR / 2,
  localparam int CNT_W = $clog2(LEVELS),
  localparam int SW    = REF_W + 2
) (
  input  logic [CW-1:0]        cnt,
  input  logic [CW-1:0]        period_q,
  input  carrier_mode_e        mode_q,
  input  logic signed [REF_W-1:0] ref_q,
  output logic [CNT_W-1:0]     above_cnt
);

  logic signed [SW-1:0] p_s;
  logic signed [SW-1:0] c_s;
  logic signed [SW-1:0] r_s;
  logic [NCAR-1:0]      above;

  assign p_s = signed'({{(SW-CW){1'b0}}, period_q});
  assign c_s = signed'({{(SW-CW){1'b0}}, cnt});
  assign r_s = {{(SW-REF_W){ref_q[REF_W-1]}}, ref_q};

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam int OFS = k - HALF;
    logic                 inv;
    logic signed [SW-1:0] tri_s;
    logic signed [SW-1:0] car_s;
    assign inv      = carrier_inverted(mode_q, k, NCAR);
    assign tri_s    = inv ? (p_s - c_s) : c_s;
    assign car_s    = SW'(OFS) * p_s + tri_s;
    assign above[k] = (r_s > car_s);
  end

  always_comb begin
    above_cnt = '0;
    for (int k = 0; k < NCAR; k++) begin
      above_cnt = above_cnt + CNT_W'(above[k]);
    end
  end

endmodule

// File: rtl/mpwm_level_map.sv
`timescale 1ns/1ps
module mpwm_level_map #(
  parameter int LEVELS = 5,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = NCAR / 2,
  localparam int CNT_W = $clog2(LEVELS),
  localparam int LW    = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     above_cnt,
  output logic signed [LW-1:0] level,
  output logic [NCAR-1:0]      gate_hi,
  output logic [NCAR-1:0]      gate_lo
);

  logic signed [LW-1:0] level_d;
  logic [NCAR-1:0]      hi_d;

  assign level_d = signed'({1'b0, above_cnt}) - LW'(HALF);

  // Thermometer: switch j conducts once enough carriers are exceeded
  for (genvar j = 0; j < NCAR; j++) begin : g_sw
    assign hi_d[j] = (above_cnt >= CNT_W'(NCAR - j));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      gate_hi <= '0;
      gate_lo <= '0;
    end else begin
      level   <= level_d;
      gate_hi <= hi_d;
      gate_lo <= ~hi_d;
    end
  end

endmodule

// File: rtl/mpwm_modulator.sv
`timescale 1ns/1ps
module mpwm_modulator
  import mpwm_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int CW     = 8,
  parameter int REF_W  = CW + 2,
  localparam int NCAR  = LEVELS - 1,
  localparam int CNT_W = $clog2(LEVELS),
  localparam int LW    = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           period,
  input  logic [1:0]              mode,
  input  logic signed [REF_W-1:0] ref_data,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  output logic signed [LW-1:0]    level,
  output logic [NCAR-1:0]         gate_hi,
  output logic [NCAR-1:0]         gate_lo
);

  logic [CW-1:0]           cnt;
  logic [CW-1:0]           period_q;
  carrier_mode_e           mode_q;
  logic signed [REF_W-1:0] ref_q;
  logic [CNT_W-1:0]        above_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ready <= 1'b0;
      ref_q     <= '0;
    end else begin
      ref_ready <= 1'b1;
      if (ref_valid && ref_ready) ref_q <= ref_data;
    end
  end

  mpwm_tri_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_in(period),
    .mode_in  (mode),
    .cnt      (cnt),
    .period_q (period_q),
    .mode_q   (mode_q)
  );

  mpwm_carrier_compare #(.LEVELS(LEVELS), .CW(CW), .REF_W(REF_W)) u_cmp (
    .cnt      (cnt),
    .period_q (period_q),
    .mode_q   (mode_q),
    .ref_q    (ref_q),
    .above_cnt(above_cnt)
  );

  mpwm_level_map #(.LEVELS(LEVELS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .above_cnt(above_cnt),
    .level    (level),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
  );

endmodule

// File: rtl/mpwm_checker.sv
`timescale 1ns/1ps
module mpwm_checker #(
  parameter int LEVELS = 5,
  parameter int CW     = 8,
  parameter int REF_W  = CW + 2,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = NCAR / 2,
  localparam int LW    = $clog2(LEVELS) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CW-1:0]           cnt,
  input logic [CW-1:0]           period_q,
  input logic [1:0]              mode_q,
  input logic signed [REF_W-1:0] ref_q,
  input logic signed [REF_W-1:0] ref_data,
  input logic                    ref_valid,
  input logic                    ref_ready,
  input logic signed [LW-1:0]    level,
  input logic [NCAR-1:0]         gate_hi,
  input logic [NCAR-1:0]         gate_lo
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (level == '0 && gate_hi == '0 && gate_lo == '0 && !ref_ready));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_q);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |->
      (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
       ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})));

  // R7
  mode_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(cnt) == '0));

  // R7
  period_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period_q) |-> ($past(cnt) == '0));

  // R8
  gate_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_hi | gate_lo)) |-> ($countones(gate_hi) == int'(level) + HALF));

  // R8
  gate_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_hi | gate_lo)) |-> ((gate_hi ^ gate_lo) == '1));

  // R9
  ref_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_valid && ref_ready) |-> (ref_q == $past(ref_data)));

  // R9
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_valid && ref_ready) |-> $stable(ref_q));

endmodule

bind mpwm_modulator mpwm_checker #(.LEVELS(LEVELS), .CW(CW), .REF_W(REF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt),
  .period_q (period_q),
  .mode_q   (mode_q),
  .ref_q    (ref_q),
  .ref_data (ref_data),
  .ref_valid(ref_valid),
  .ref_ready(ref_ready),
  .level    (level),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo)
);

// File: tb/sim_mpwm_modulator.sv
`timescale 1ns/1ps
module sim_mpwm_modulator;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        period = 8'd0;
  logic [1:0]        mode = 2'd0;
  logic signed [9:0] ref_data = '0;
  logic              ref_valid = 1'b0;
  logic              rdy0, rdy1;
  logic signed [3:0] lvl0;
  logic signed [2:0] lvl1;
  logic [3:0]        hi0, lo0;
  logic [1:0]        hi1, lo1;

  always #10 clk = ~clk;

  mpwm_modulator #(.LEVELS(5), .CW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .mode(mode),
    .ref_data(ref_data), .ref_valid(ref_valid), .ref_ready(rdy0),
    .level(lvl0), .gate_hi(hi0), .gate_lo(lo0));

  mpwm_modulator #(.LEVELS(3), .CW(8)) u1 (
    .clk(clk), .rst_n(rst_n), .period(period), .mode(mode),
    .ref_data(ref_data), .ref_valid(ref_valid), .ref_ready(rdy1),
    .level(lvl1), .gate_hi(hi1), .gate_lo(lo1));

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  // Behavioural model state, index 0 = five levels, 1 = three levels
  int m_cnt[2], m_up[2], m_per[2], m_mode[2], m_ref[2], m_rdy[2];
  int e_lvl[2], e_hi[2], e_lo[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      int m, h, c, t, car, inv, peff;
      m = (i == 0) ? 4 : 2;
      h = m / 2;
      if (!rst_n) begin
        m_cnt[i] = 0; m_up[i] = 1; m_per[i] = 0; m_mode[i] = 0;
        m_ref[i] = 0; m_rdy[i] = 0;
        e_lvl[i] = 0; e_hi[i] = 0; e_lo[i] = 0;
      end else begin
        c = 0;
        for (int k = 0; k < m; k++) begin
          if (m_mode[i] == 1)      inv = (k < h) ? 1 : 0;
          else if (m_mode[i] == 2) inv = k % 2;
          else                     inv = 0;
          t = inv ? (m_per[i] - m_cnt[i]) : m_cnt[i];
          car = (k - h) * m_per[i] + t;
          if (m_ref[i] > car) c++;
        end
        e_lvl[i] = c - h;
        e_hi[i] = 0;
        for (int j = 0; j < m; j++) if (c >= m - j) e_hi[i] |= (1 << j);
        e_lo[i] = (~e_hi[i]) & ((1 << m) - 1);
        if (m_rdy[i] != 0 && ref_valid) m_ref[i] = int'(ref_data);
        m_rdy[i] = 1;
        if (m_cnt[i] == 0) begin
          peff = int'(period); m_per[i] = peff; m_mode[i] = int'(mode);
        end else peff = m_per[i];
        if (m_up[i] != 0) begin
          if (m_cnt[i] + 1 >= peff) begin m_cnt[i] = peff; m_up[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end else begin
          if (m_cnt[i] <= 1) begin m_cnt[i] = 0; m_up[i] = 1; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare both instances with the model away from the active edge
  task automatic tick();
    @(negedge clk);
    chk(cur_req, int'(lvl0), e_lvl[0]);
    chk(cur_req, int'(lvl1), e_lvl[1]);
    chk("R8", int'(hi0), e_hi[0]);
    chk("R8", int'(lo0), e_lo[0]);
    chk("R8", int'(hi1), e_hi[1]);
    chk("R8", int'(lo1), e_lo[1]);
    chk("R9", int'(rdy0), m_rdy[0]);
    chk("R9", int'(rdy1), m_rdy[1]);
  endtask

  function automatic int sine_at(int n, int amp);
    return $rtoi($floor(real'(amp) * $sin(6.2831853 * real'(n) / 40.0) + 0.5));
  endfunction

  task automatic run_sine(int cycles, int amp, int mode_step);
    for (int n = 0; n < cycles; n++) begin
      tick();
      ref_data  = 10'(sine_at(n, amp));
      ref_valid = 1'b1;
      if (mode_step > 0 && (n % mode_step) == 0) mode = mode + 2'd1;
    end
  endtask

  task automatic run_const(int cycles, int value);
    ref_data = 10'(value);
    for (int n = 0; n < cycles; n++) tick();
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1: outputs idle during reset
    cur_req = "R1";
    repeat (3) tick();
    rst_n  = 1'b1;
    period = 8'd6;
    mode   = 2'd0;
    // R4: aligned carriers, then mode 3
    cur_req = "R4";
    run_sine(60, 12, 0);
    mode = 2'd3;
    run_sine(30, 12, 0);
    // R5: opposed about zero
    cur_req = "R5";
    mode = 2'd1;
    run_sine(60, 12, 0);
    // R6: alternating neighbours
    cur_req = "R6";
    mode = 2'd2;
    run_sine(60, 12, 0);
    // R7: mode toggles off the valley while samples stream
    cur_req = "R7";
    run_sine(120, 11, 5);
    // R10: saturation at both ends
    cur_req = "R10";
    mode = 2'd2;
    run_const(30, 600);
    run_const(30, -12);
    run_const(30, -600);
    run_const(30, 12);
    // R9: samples ignored while valid is low
    cur_req = "R9";
    ref_valid = 1'b0;
    for (int n = 0; n < 30; n++) begin
      tick();
      ref_data = 10'(sine_at(n * 3, 12));
    end
    ref_valid = 1'b1;
    // R2: period changes, including zero
    cur_req = "R2";
    period = 8'd3;
    run_sine(40, 6, 0);
    period = 8'd0;
    run_sine(20, 6, 0);
    period = 8'd9;
    mode = 2'd1;
    run_sine(80, 18, 7);
    // R3: level steps across held references
    cur_req = "R3";
    period = 8'd6;
    mode = 2'd0;
    for (int v = -12; v <= 12; v += 3) run_const(14, v);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule